// File: doc/BRIEF.md
# Directory-Coherent Node Cache Controller

This block is the cache-side coherence engine for one processing node in a shared-memory system where coherence is kept by a home directory and not by a broadcast bus. It holds a small direct-mapped write-back cache of one-word lines. Each line carries a tag, a data word and one of three coherence states: Invalid, Shared or Exclusive. When the processor misses, the controller sends an explicit point-to-point request to the home node and stalls the processor until the data reply returns. Messages that the home node sends to this node act on the cached copy. An invalidate drops the copy. A fetch returns the data and keeps a read-only copy. A fetch-and-invalidate returns the data and drops the copy.

The processor side is a blocking request/response port. The network side is a pair of message ports: one outgoing, one incoming. Each carries a 3-bit message type, an address and a data word, and the outgoing port also carries this node's id. A message is present for one cycle and needs no handshake. The network is assumed to deliver messages in the order they were sent.

Top module: `dnc_node_ctrl`

## Requirements
- R1: After reset every line is Invalid, no message is sent, no response is given and the processor port is ready, so the first access to any address misses.
- R2: A read whose address tag matches a Shared or Exclusive line gives a response one cycle later with the cached word and sends no message.
- R3: A read that misses sends a read-miss message (type 0) with the full address one cycle after acceptance, and the processor port stays not-ready until the data reply arrives.
- R4: A write to a line not held Exclusive (Invalid, other tag, or a Shared hit) sends a write-miss message (type 1) carrying the address.
- R5: A write that hits an Exclusive line stores the word, answers one cycle later and sends no message; a later read returns the new word.
- R6: A data reply (type 5) received while waiting installs the line and answers the processor one cycle later. After a read miss the line becomes Shared and the response carries the reply data. After a write miss the line becomes Exclusive and holds the processor's write word, which is also returned.
- R7: An invalidate (type 2) whose address matches a held line makes it Invalid. An invalidate for a different tag at the same index has no effect.
- R8: A fetch (type 3) that matches an Exclusive line sends a data write-back (type 6) with that address and word one cycle later, and the line becomes Shared: reads still hit and a write sends a write-miss.
- R9: A fetch-and-invalidate (type 4) that matches an Exclusive line sends a data write-back (type 6) with the word one cycle later and makes the line Invalid.
- R10: A miss whose line index holds an Exclusive line with another tag first sends a data write-back (type 6) carrying the victim address (victim tag above the index bits) and word. The miss message follows in the next free cycle.
- R11: Invalidate, fetch and fetch-and-invalidate messages are handled in any cycle, also while a miss is outstanding. In a cycle that carries one, the processor port is not ready and a request offered is not taken. A pending miss message is deferred by one cycle.
- R12: Every outgoing message carries this node's id in its source field and uses only types 0, 1 or 6. The line index is the low address bits and the tag is the remaining high bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor offers a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_req_ready | output | 1 | Request taken this cycle when valid |
| cpu_resp_valid | output | 1 | Response pulse |
| cpu_resp_rdata | output | DATA_W | Read word or written word |
| tx_valid | output | 1 | Outgoing message present |
| tx_type | output | 3 | Outgoing message type |
| tx_src | output | NODE_W | This node's id |
| tx_addr | output | ADDR_W | Outgoing message address |
| tx_data | output | DATA_W | Outgoing data (write-back) |
| rx_valid | input | 1 | Incoming message present |
| rx_type | input | 3 | Incoming message type |
| rx_addr | input | ADDR_W | Incoming message address |
| rx_data | input | DATA_W | Incoming data (reply) |

## Verification
The bench builds the block with four lines, 8-bit addresses, 16-bit words and node id 3. With this setup, addresses such as 0x05, 0x09 and 0x0D share one index. A dirty victim, a same-index invalidate with a foreign tag and a refill after eviction can each be reached in a few cycles. These parameters also make it easy to place a coherence message exactly in the cycle between a victim write-back and its deferred miss, and during the wait for a reply.

// File: rtl/dnc_pkg.sv
package dnc_pkg;
  typedef enum logic [2:0] {
    MSG_RD_MISS    = 3'd0,
    MSG_WR_MISS    = 3'd1,
    MSG_INVAL      = 3'd2,
    MSG_FETCH      = 3'd3,
    MSG_FETCH_INV  = 3'd4,
    MSG_DATA_REPLY = 3'd5,
    MSG_WRITE_BACK = 3'd6
  } msg_e;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_e;

  typedef enum logic [1:0] {
    CT_IDLE = 2'd0,
    CT_SEND = 2'd1,
    CT_WAIT = 2'd2
  } ctl_e;
endpackage

// File: rtl/dnc_line_store.sv
module dnc_line_store
  import dnc_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  a_idx,
  output line_e             a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_e             b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_state_en,
  input  line_e             wr_state,
  input  logic              wr_line_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  line_e             st_q     [DEPTH];

  // tag and data: plain RAM, no reset
  always_ff @(posedge clk) begin
    if (wr_line_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  // coherence states: reset to Invalid
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= LN_INV;
    end else if (wr_state_en) begin
      st_q[wr_idx] <= wr_state;
    end
  end

  assign a_state = st_q[a_idx];
  assign a_tag   = tag_mem[a_idx];
  assign a_data  = data_mem[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_mem[b_idx];
  assign b_data  = data_mem[b_idx];
endmodule

// File: rtl/dnc_snoop_resp.sv
module dnc_snoop_resp
  import dnc_pkg::*;
(
  input  logic       rx_valid,
  input  logic [2:0] rx_type,
  input  line_e      cur_state,
  input  logic       tag_hit,
  output logic       is_coh,
  output logic       upd_en,
  output line_e      upd_state,
  output logic       send_data
);
  logic held;
  assign held = (cur_state != LN_INV) && tag_hit;

  always_comb begin
    is_coh    = rx_valid && ((rx_type == MSG_INVAL) || (rx_type == MSG_FETCH) ||
                             (rx_type == MSG_FETCH_INV));
    upd_en    = 1'b0;
    upd_state = cur_state;
    send_data = 1'b0;
    if (is_coh && held) begin
      case (rx_type)
        MSG_INVAL: begin
          upd_en    = 1'b1;
          upd_state = LN_INV;
        end
        MSG_FETCH: begin
          if (cur_state == LN_EXC) begin
            upd_en    = 1'b1;
            upd_state = LN_SHR;
            send_data = 1'b1;
          end
        end
        default: begin
          upd_en    = 1'b1;
          upd_state = LN_INV;
          send_data = (cur_state == LN_EXC);
        end
      endcase
    end
  end
endmodule

// File: rtl/dnc_node_ctrl.sv
module dnc_node_ctrl
  import dnc_pkg::*;
#(
  parameter int NODE_W  = 2,
  parameter int NODE_ID = 1,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int LINES   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_resp_valid,
  output logic [DATA_W-1:0] cpu_resp_rdata,
  output logic              tx_valid,
  output logic [2:0]        tx_type,
  output logic [NODE_W-1:0] tx_src,
  output logic [ADDR_W-1:0] tx_addr,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  input  logic [2:0]        rx_type,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [DATA_W-1:0] rx_data
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_e fsm_q;

  logic [ADDR_W-1:0] p_addr;
  logic              p_write;
  logic [DATA_W-1:0] p_wdata;

  logic [IDX_W-1:0] cpu_idx, rx_idx, p_idx;
  logic [TAG_W-1:0] cpu_tag, rx_tag, p_tag;
  assign cpu_idx = cpu_req_addr[IDX_W-1:0];
  assign cpu_tag = cpu_req_addr[ADDR_W-1:IDX_W];
  assign rx_idx  = rx_addr[IDX_W-1:0];
  assign rx_tag  = rx_addr[ADDR_W-1:IDX_W];
  assign p_idx   = p_addr[IDX_W-1:0];
  assign p_tag   = p_addr[ADDR_W-1:IDX_W];

  line_e             a_state, b_state;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;

  logic [IDX_W-1:0]  wr_idx;
  logic              wr_state_en, wr_line_en;
  line_e             wr_state;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;

  dnc_line_store #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .a_idx      (cpu_idx),
    .a_state    (a_state),
    .a_tag      (a_tag),
    .a_data     (a_data),
    .b_idx      (rx_idx),
    .b_state    (b_state),
    .b_tag      (b_tag),
    .b_data     (b_data),
    .wr_idx     (wr_idx),
    .wr_state_en(wr_state_en),
    .wr_state   (wr_state),
    .wr_line_en (wr_line_en),
    .wr_tag     (wr_tag),
    .wr_data    (wr_data)
  );

  logic  is_coh, upd_en, send_data;
  line_e upd_state;

  dnc_snoop_resp u_snoop (
    .rx_valid (rx_valid),
    .rx_type  (rx_type),
    .cur_state(b_state),
    .tag_hit  (b_tag == rx_tag),
    .is_coh   (is_coh),
    .upd_en   (upd_en),
    .upd_state(upd_state),
    .send_data(send_data)
  );

  logic accept, cpu_hit, wr_hit_exc, victim_dirty, reply_take;
  assign accept       = (fsm_q == CT_IDLE) && cpu_req_valid && !is_coh;
  assign cpu_hit      = (a_state != LN_INV) && (a_tag == cpu_tag);
  assign wr_hit_exc   = cpu_req_write && cpu_hit && (a_state == LN_EXC);
  assign victim_dirty = !cpu_hit && (a_state == LN_EXC);
  assign reply_take   = (fsm_q == CT_WAIT) && rx_valid && (rx_type == MSG_DATA_REPLY);

  assign cpu_req_ready = (fsm_q == CT_IDLE) && !is_coh;
  assign tx_src        = NODE_W'(NODE_ID);

  // single write port into the line store
  always_comb begin
    wr_idx      = cpu_idx;
    wr_state_en = 1'b0;
    wr_state    = LN_INV;
    wr_line_en  = 1'b0;
    wr_tag      = cpu_tag;
    wr_data     = cpu_req_wdata;
    if (is_coh) begin
      wr_idx      = rx_idx;
      wr_state_en = upd_en;
      wr_state    = upd_state;
    end else if (accept) begin
      if (wr_hit_exc) begin
        wr_line_en = 1'b1;
      end else if (victim_dirty) begin
        wr_state_en = 1'b1;
        wr_state    = LN_INV;
      end
    end else if (reply_take) begin
      wr_idx      = p_idx;
      wr_tag      = p_tag;
      wr_line_en  = 1'b1;
      wr_state_en = 1'b1;
      wr_state    = p_write ? LN_EXC : LN_SHR;
      wr_data     = p_write ? p_wdata : rx_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q          <= CT_IDLE;
      p_addr         <= '0;
      p_write        <= 1'b0;
      p_wdata        <= '0;
      tx_valid       <= 1'b0;
      tx_type        <= 3'd0;
      tx_addr        <= '0;
      tx_data        <= '0;
      cpu_resp_valid <= 1'b0;
      cpu_resp_rdata <= '0;
    end else begin
      tx_valid       <= 1'b0;
      cpu_resp_valid <= 1'b0;
      if (is_coh) begin
        if (send_data) begin
          tx_valid <= 1'b1;
          tx_type  <= MSG_WRITE_BACK;
          tx_addr  <= rx_addr;
          tx_data  <= b_data;
        end
      end else begin
        case (fsm_q)
          CT_IDLE: begin
            if (accept) begin
              if (cpu_hit && (!cpu_req_write || a_state == LN_EXC)) begin
                cpu_resp_valid <= 1'b1;
                cpu_resp_rdata <= cpu_req_write ? cpu_req_wdata : a_data;
              end else begin
                p_addr  <= cpu_req_addr;
                p_write <= cpu_req_write;
                p_wdata <= cpu_req_wdata;
                tx_valid <= 1'b1;
                if (victim_dirty) begin
                  tx_type <= MSG_WRITE_BACK;
                  tx_addr <= {a_tag, cpu_idx};
                  tx_data <= a_data;
                  fsm_q   <= CT_SEND;
                end else begin
                  tx_type <= cpu_req_write ? MSG_WR_MISS : MSG_RD_MISS;
                  tx_addr <= cpu_req_addr;
                  fsm_q   <= CT_WAIT;
                end
              end
            end
          end
          CT_SEND: begin
            tx_valid <= 1'b1;
            tx_type  <= p_write ? MSG_WR_MISS : MSG_RD_MISS;
            tx_addr  <= p_addr;
            fsm_q    <= CT_WAIT;
          end
          CT_WAIT: begin
            if (reply_take) begin
              cpu_resp_valid <= 1'b1;
              cpu_resp_rdata <= p_write ? p_wdata : rx_data;
              fsm_q          <= CT_IDLE;
            end
          end
          default: fsm_q <= CT_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dnc_node_ctrl_chk.sv
module dnc_node_ctrl_chk
  import dnc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cpu_req_valid,
  input logic       cpu_req_ready,
  input logic       cpu_resp_valid,
  input logic       tx_valid,
  input logic [2:0] tx_type,
  input logic       rx_valid,
  input logic [2:0] rx_type,
  input ctl_e       fsm_q
);
  logic coh_in, reply_in;
  assign coh_in   = rx_valid && (rx_type == 3'd2 || rx_type == 3'd3 || rx_type == 3'd4);
  assign reply_in = rx_valid && (rx_type == 3'd5);

  a_r11_coh_blocks_cpu: assert property (@(posedge clk) disable iff (rst)
    coh_in |-> !cpu_req_ready);

  a_r3_miss_blocks_cpu: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && (tx_type == 3'd0 || tx_type == 3'd1)) |-> !cpu_req_ready);

  a_r6_reply_answers: assert property (@(posedge clk) disable iff (rst)
    (fsm_q == CT_WAIT && reply_in) |=> cpu_resp_valid);

  a_r2_resp_has_cause: assert property (@(posedge clk) disable iff (rst)
    cpu_resp_valid |-> ($past(cpu_req_valid && cpu_req_ready) ||
                        $past(fsm_q == CT_WAIT && reply_in)));

  a_r10_miss_after_wb: assert property (@(posedge clk) disable iff (rst)
    (fsm_q == CT_SEND && !coh_in) |=> (tx_valid && (tx_type == 3'd0 || tx_type == 3'd1)));

  a_r12_tx_type_legal: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_type == 3'd0 || tx_type == 3'd1 || tx_type == 3'd6));
endmodule

bind dnc_node_ctrl dnc_node_ctrl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .cpu_resp_valid(cpu_resp_valid),
  .tx_valid      (tx_valid),
  .tx_type       (tx_type),
  .rx_valid      (rx_valid),
  .rx_type       (rx_type),
  .fsm_q         (fsm_q)
);

// File: tb/test_dnc_node_ctrl.sv
module test_dnc_node_ctrl;
  localparam int L = 4;
  localparam int NID = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_v = 0, req_w = 0;
  logic [7:0]  req_a = 0;
  logic [15:0] req_d = 0;
  logic        rx_v = 0;
  logic [2:0]  rx_t = 0;
  logic [7:0]  rx_a = 0;
  logic [15:0] rx_d = 0;

  logic        ready, resp_v, txv;
  logic [15:0] rdata, txd;
  logic [2:0]  txt;
  logic [1:0]  txs;
  logic [7:0]  txa;

  dnc_node_ctrl #(.NODE_W(2), .NODE_ID(NID), .ADDR_W(8), .DATA_W(16), .LINES(L)) i_dnc_node_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req_valid(req_v), .cpu_req_write(req_w), .cpu_req_addr(req_a), .cpu_req_wdata(req_d),
    .cpu_req_ready(ready), .cpu_resp_valid(resp_v), .cpu_resp_rdata(rdata),
    .tx_valid(txv), .tx_type(txt), .tx_src(txs), .tx_addr(txa), .tx_data(txd),
    .rx_valid(rx_v), .rx_type(rx_t), .rx_addr(rx_a), .rx_data(rx_d)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: per-line state 0=I 1=S 2=E, mode 0 idle 1 send 2 wait
  int mst[L], mtag[L], mdata[L];
  int mmode, pa, pw, pd, ix, tg;
  int e_txv, e_txt, e_txa, e_txd, e_rv, e_rd;

  function automatic bit is_coh(logic v, logic [2:0] t);
    return v && (t == 2 || t == 3 || t == 4);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < L; i++) mst[i] = 0;
      mmode = 0; e_txv = 0; e_rv = 0;
    end else begin
      e_txv = 0; e_rv = 0;
      if (is_coh(rx_v, rx_t)) begin
        ix = rx_a % L; tg = rx_a / L;
        if (mst[ix] != 0 && mtag[ix] == tg) begin
          if (rx_t == 2) mst[ix] = 0;
          else if (rx_t == 3) begin
            if (mst[ix] == 2) begin e_txv = 1; e_txt = 6; e_txa = rx_a; e_txd = mdata[ix]; mst[ix] = 1; end
          end else begin
            if (mst[ix] == 2) begin e_txv = 1; e_txt = 6; e_txa = rx_a; e_txd = mdata[ix]; end
            mst[ix] = 0;
          end
        end
      end else if (mmode == 0 && req_v) begin
        ix = req_a % L; tg = req_a / L;
        if (mst[ix] != 0 && mtag[ix] == tg && !req_w) begin
          e_rv = 1; e_rd = mdata[ix];
        end else if (mst[ix] == 2 && mtag[ix] == tg && req_w) begin
          mdata[ix] = req_d; e_rv = 1; e_rd = req_d;
        end else begin
          pa = req_a; pw = req_w; pd = req_d;
          e_txv = 1;
          if (mst[ix] == 2) begin
            e_txt = 6; e_txa = mtag[ix] * L + ix; e_txd = mdata[ix]; mst[ix] = 0; mmode = 1;
          end else begin
            e_txt = req_w ? 1 : 0; e_txa = req_a; mmode = 2;
          end
        end
      end else if (mmode == 1) begin
        e_txv = 1; e_txt = pw ? 1 : 0; e_txa = pa; mmode = 2;
      end else if (mmode == 2 && rx_v && rx_t == 5) begin
        ix = pa % L;
        mtag[ix] = pa / L; mst[ix] = pw ? 2 : 1; mdata[ix] = pw ? pd : rx_d;
        e_rv = 1; e_rd = mdata[ix]; mmode = 0;
      end
    end
  end

  task automatic compare();
    chk("R11 ready vs model", ready, (mmode == 0 && !is_coh(rx_v, rx_t)));
    chk("R12 tx_valid vs model", txv, e_txv);
    if (e_txv != 0) begin
      chk("R12 tx_type vs model", txt, e_txt);
      chk("R12 tx_addr vs model", txa, e_txa);
      chk("R12 tx_src", txs, NID);
      if (e_txt == 6) chk("R10 tx_data vs model", txd, e_txd);
    end
    chk("R2 resp_valid vs model", resp_v, e_rv);
    if (e_rv != 0) chk("R6 resp_rdata vs model", rdata, e_rd);
  endtask

  task automatic cyc(logic v, logic w, logic [7:0] a, logic [15:0] d,
                     logic rv, logic [2:0] rt, logic [7:0] ra, logic [15:0] rd);
    req_v = v; req_w = w; req_a = a; req_d = d;
    rx_v = rv; rx_t = rt; rx_a = ra; rx_d = rd;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();    cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rd(logic [7:0] a); cyc(1, 0, a, 0, 0, 0, 0, 0); endtask
  task automatic wr(logic [7:0] a, logic [15:0] d); cyc(1, 1, a, d, 0, 0, 0, 0); endtask
  task automatic msg(logic [2:0] t, logic [7:0] a, logic [15:0] d); cyc(0, 0, 0, 0, 1, t, a, d); endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 ready after reset", ready, 1);
    chk("R1 no tx after reset", txv, 0);
    chk("R1 no resp after reset", resp_v, 0);

    rd(8'h05);
    chk("R1 first read misses", txv, 1);
    chk("R3 read-miss type", txt, 0);
    chk("R3 read-miss addr", txa, 8'h05);
    chk("R12 src id", txs, NID);
    chk("R3 blocked", ready, 0);
    idle();
    chk("R3 still blocked", ready, 0);
    msg(5, 8'h05, 16'hAAAA);
    chk("R6 read reply resp", resp_v, 1);
    chk("R6 read reply data", rdata, 16'hAAAA);

    rd(8'h05);
    chk("R2 hit resp", resp_v, 1);
    chk("R2 hit data", rdata, 16'hAAAA);
    chk("R2 hit no msg", txv, 0);

    rd(8'h02);
    msg(5, 8'h02, 16'hBBBB);

    wr(8'h05, 16'h1111);
    chk("R4 shared write sends msg", txv, 1);
    chk("R4 write-miss type", txt, 1);
    msg(5, 8'h05, 16'h0000);
    chk("R6 write reply data", rdata, 16'h1111);

    wr(8'h05, 16'h2222);
    chk("R5 exclusive write resp", resp_v, 1);
    chk("R5 exclusive write no msg", txv, 0);
    rd(8'h05);
    chk("R5 read back", rdata, 16'h2222);

    msg(3, 8'h05, 0);
    chk("R8 fetch write-back", txt, 6);
    chk("R8 fetch data", txd, 16'h2222);
    rd(8'h05);
    chk("R8 still readable", rdata, 16'h2222);
    wr(8'h05, 16'h3333);
    chk("R8 now shared: write-miss", txt, 1);
    msg(5, 8'h05, 0);

    rd(8'h09);
    chk("R10 victim write-back type", txt, 6);
    chk("R10 victim addr", txa, 8'h05);
    chk("R10 victim data", txd, 16'h3333);
    idle();
    chk("R10 miss follows", txt, 0);
    chk("R10 miss addr", txa, 8'h09);
    msg(5, 8'h09, 16'h4444);

    msg(2, 8'h0D, 0);
    rd(8'h09);
    chk("R7 foreign-tag inval ignored", rdata, 16'h4444);

    cyc(1, 0, 8'h09, 0, 1, 2, 8'h33, 0);
    chk("R11 not ready with coh msg", ready, 0);
    chk("R11 request not taken", resp_v, 0);
    idle();
    chk("R11 no late response", resp_v, 0);

    msg(2, 8'h09, 0);
    rd(8'h09);
    chk("R7 invalidated line misses", txt, 0);
    msg(2, 8'h02, 0);
    chk("R11 blocked during wait", ready, 0);
    msg(5, 8'h09, 16'h6666);
    rd(8'h02);
    chk("R11 inval during wait applied", txv, 1);
    msg(5, 8'h02, 16'h7777);

    wr(8'h06, 16'h5555);
    msg(5, 8'h06, 0);
    msg(4, 8'h06, 0);
    chk("R9 fetch-inv write-back", txt, 6);
    chk("R9 fetch-inv data", txd, 16'h5555);
    rd(8'h06);
    chk("R9 line now invalid", txt, 0);
    msg(5, 8'h06, 16'h8888);

    wr(8'h0A, 16'h1234);
    msg(5, 8'h0A, 0);
    rd(8'h0E);
    chk("R10 second victim", txa, 8'h0A);
    msg(2, 8'h09, 0);
    chk("R11 miss deferred by coh msg", txv, 0);
    idle();
    chk("R10 deferred miss addr", txa, 8'h0E);
    msg(5, 8'h0E, 16'h9999);
    chk("R6 final reply", rdata, 16'h9999);
    idle();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule